// File: doc/BRIEF.md
# Banked File-Register Data Memory

This block is the byte-wide data store of an accumulator-style 8-bit core. Instructions carry only an 8-bit address field and a one-bit bank selector, so the block widens that field to a 12-bit byte address itself. It uses either a 4-bit bank register held inside the block or a fixed split "quick" window. The low half of that window reaches the bottom of the address space, which holds general-purpose bytes. Its high half reaches the top 128 bytes, where control registers live.

The core reads through one field-addressed port and writes through another. It loads the bank register from a 4-bit literal. A separate full-address port lets a 12-bit address reach any byte without the bank register, for example for a two-word memory-to-memory move. Storage is built only for the 128-byte segments that a parameter marks as present. By default these are banks 0, 1 and 2 and the top region 0xF80-0xFFF. Every other address reads as zero and drops writes.

Top module: `fregs_mem`

## Requirements
- R1: With `rd_banked`/`wr_banked` = 1, the byte address is {bank register, field}, with the bank register in bits 11:8.
- R2: With the banked bit 0 and field bit 7 clear, the address is 0x000 plus the field, whatever the bank register holds.
- R3: With the banked bit 0 and field bit 7 set, the address is 0xF00 plus the field, which gives 0xF80-0xFFF.
- R4: The bank register resets to 0 and takes `bsr_lit` on a rising edge with `bsr_load` high. A field write in that same cycle uses the value held before the load.
- R5: The direct port addresses a byte with the full 12-bit `dir_addr` and ignores the bank register and both banked bits.
- R6: By default only bytes 0x000-0x2FF and 0xF80-0xFFF exist. A read anywhere else returns 0x00, and a write anywhere else is lost.
- R7: Both read ports are combinational. A byte changes only on a rising edge with its write enable high.
- R8: A read of a byte that is being written in the same cycle returns the value the byte held before that write.
- R9: If both write ports target the same byte in one cycle, the field port's data is stored. If they target different bytes, both writes land.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bsr_load | input | 1 | Load the bank register from `bsr_lit` |
| bsr_lit | input | 4 | Bank literal |
| rd_field | input | 8 | Read address field |
| rd_banked | input | 1 | 1: use the bank register for the read, 0: use the quick window |
| rd_data | output | 8 | Read data, combinational |
| wr_en | input | 1 | Field write enable |
| wr_field | input | 8 | Write address field |
| wr_banked | input | 1 | 1: use the bank register for the write, 0: use the quick window |
| wr_data | input | 8 | Field write data |
| dir_addr | input | 12 | Full byte address for the direct port |
| dir_wr_en | input | 1 | Direct write enable |
| dir_wr_data | input | 8 | Direct write data |
| dir_rd_data | output | 8 | Direct read data, combinational |

## Verification
Two functions can fall in the same edge: a bank-register load and a banked field write. The bench sets the register to 1, then raises `bsr_load` with literal 2 together with a banked write to field 0x40. Through the direct port it then expects the data at 0x140 and an untouched byte at 0x240. A write and a read of the same byte in one cycle, and two writes from both ports to one byte, are also driven. These are judged by sampling before and after the edge.

// File: rtl/fregs_pkg.sv
package fregs_pkg;
  localparam int ADDR_W  = 12;
  localparam int FIELD_W = 8;
  localparam int DATA_W  = 8;
  localparam int SEG_AW  = 7;
  localparam int BSR_W   = ADDR_W - FIELD_W;
  localparam int NSEG    = 1 << (ADDR_W - SEG_AW);
  localparam int SEL_W   = ADDR_W - SEG_AW;
endpackage

// File: rtl/fregs_addr_map.sv
module fregs_addr_map
  import fregs_pkg::*;
(
  input  logic [FIELD_W-1:0] field,
  input  logic               banked,
  input  logic [BSR_W-1:0]   bsr,
  output logic [ADDR_W-1:0]  addr
);
  always_comb begin
    if (banked)
      addr = {bsr, field};
    else if (field[FIELD_W-1])
      addr = {{BSR_W{1'b1}}, field};
    else
      addr = {{BSR_W{1'b0}}, field};
  end
endmodule

// File: rtl/fregs_bsr.sv
module fregs_bsr
  import fregs_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n_i,
  input  logic             load,
  input  logic [BSR_W-1:0] lit,
  output logic [BSR_W-1:0] bsr_q
);
  logic [BSR_W-1:0] bsr_d;

  always_comb begin
    bsr_d = bsr_q;
    if (load) bsr_d = lit;
  end

  always_ff @(posedge clk or negedge rst_n_i) begin
    if (!rst_n_i) bsr_q <= '0;
    else          bsr_q <= bsr_d;
  end

  // R4
  bsr_load_chk: assert property (@(posedge clk) disable iff (!rst_n_i)
    load |=> bsr_q == $past(lit));
endmodule

// File: rtl/fregs_seg.sv
module fregs_seg
  import fregs_pkg::*;
(
  input  logic              clk,
  input  logic              we_f,
  input  logic [SEG_AW-1:0] wa_f,
  input  logic [DATA_W-1:0] wd_f,
  input  logic              we_d,
  input  logic [SEG_AW-1:0] wa_d,
  input  logic [DATA_W-1:0] wd_d,
  input  logic [SEG_AW-1:0] ra_f,
  input  logic [SEG_AW-1:0] ra_d,
  output logic [DATA_W-1:0] rd_f,
  output logic [DATA_W-1:0] rd_d
);
  localparam int DEPTH = 1 << SEG_AW;
  logic [DATA_W-1:0] arr [DEPTH];

  // field port written last so it wins on a shared byte
  always_ff @(posedge clk) begin
    if (we_d) arr[wa_d] <= wd_d;
    if (we_f) arr[wa_f] <= wd_f;
  end

  assign rd_f = arr[ra_f];
  assign rd_d = arr[ra_d];
endmodule

// File: rtl/fregs_mem.sv
module fregs_mem
  import fregs_pkg::*;
#(
  parameter logic [NSEG-1:0] IMPL_SEG = 32'h8000_003F
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               bsr_load,
  input  logic [BSR_W-1:0]   bsr_lit,
  input  logic [FIELD_W-1:0] rd_field,
  input  logic               rd_banked,
  output logic [DATA_W-1:0]  rd_data,
  input  logic               wr_en,
  input  logic [FIELD_W-1:0] wr_field,
  input  logic               wr_banked,
  input  logic [DATA_W-1:0]  wr_data,
  input  logic [ADDR_W-1:0]  dir_addr,
  input  logic               dir_wr_en,
  input  logic [DATA_W-1:0]  dir_wr_data,
  output logic [DATA_W-1:0]  dir_rd_data
);
  logic [1:0]        rst_sync;
  logic              rst_n_i;
  logic [BSR_W-1:0]  bsr_q;
  logic [ADDR_W-1:0] rd_addr, wr_addr;
  logic [DATA_W-1:0] seg_rd_f [NSEG];
  logic [DATA_W-1:0] seg_rd_d [NSEG];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_n_i = rst_sync[1];

  fregs_bsr u_bsr (
    .clk(clk), .rst_n_i(rst_n_i), .load(bsr_load), .lit(bsr_lit), .bsr_q(bsr_q)
  );

  fregs_addr_map u_rmap (
    .field(rd_field), .banked(rd_banked), .bsr(bsr_q), .addr(rd_addr)
  );
  fregs_addr_map u_wmap (
    .field(wr_field), .banked(wr_banked), .bsr(bsr_q), .addr(wr_addr)
  );

  for (genvar s = 0; s < NSEG; s++) begin : g_seg
    if (IMPL_SEG[s]) begin : g_on
      logic we_f, we_d;
      assign we_f = wr_en     && (wr_addr[ADDR_W-1:SEG_AW]  == SEL_W'(s));
      assign we_d = dir_wr_en && (dir_addr[ADDR_W-1:SEG_AW] == SEL_W'(s));
      fregs_seg u_seg (
        .clk(clk),
        .we_f(we_f), .wa_f(wr_addr[SEG_AW-1:0]),  .wd_f(wr_data),
        .we_d(we_d), .wa_d(dir_addr[SEG_AW-1:0]), .wd_d(dir_wr_data),
        .ra_f(rd_addr[SEG_AW-1:0]), .ra_d(dir_addr[SEG_AW-1:0]),
        .rd_f(seg_rd_f[s]), .rd_d(seg_rd_d[s])
      );
    end else begin : g_off
      assign seg_rd_f[s] = '0;
      assign seg_rd_d[s] = '0;
    end
  end

  assign rd_data     = seg_rd_f[rd_addr[ADDR_W-1:SEG_AW]];
  assign dir_rd_data = seg_rd_d[dir_addr[ADDR_W-1:SEG_AW]];

  // R1
  banked_map_chk: assert property (@(posedge clk) disable iff (!rst_n_i)
    rd_banked |-> rd_addr == {bsr_q, rd_field});
  // R2
  quick_low_chk: assert property (@(posedge clk) disable iff (!rst_n_i)
    (!rd_banked && !rd_field[FIELD_W-1]) |-> rd_addr[ADDR_W-1:FIELD_W-1] == '0);
  // R3
  quick_high_chk: assert property (@(posedge clk) disable iff (!rst_n_i)
    (!rd_banked && rd_field[FIELD_W-1]) |-> rd_addr[ADDR_W-1:FIELD_W-1] == '1);
  // R6
  absent_zero_chk: assert property (@(posedge clk) disable iff (!rst_n_i)
    !IMPL_SEG[dir_addr[ADDR_W-1:SEG_AW]] |-> dir_rd_data == '0);
  // R5
  direct_wr_chk: assert property (@(posedge clk) disable iff (!rst_n_i)
    (dir_wr_en && IMPL_SEG[dir_addr[ADDR_W-1:SEG_AW]] && !(wr_en && wr_addr == dir_addr))
    |=> (dir_addr != $past(dir_addr) || dir_rd_data == $past(dir_wr_data)));
endmodule

// File: tb/sim_fregs_mem.sv
module sim_fregs_mem;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        bsr_load;
  logic [3:0]  bsr_lit;
  logic [7:0]  rd_field;
  logic        rd_banked;
  logic [7:0]  rd_data;
  logic        wr_en;
  logic [7:0]  wr_field;
  logic        wr_banked;
  logic [7:0]  wr_data;
  logic [11:0] dir_addr;
  logic        dir_wr_en;
  logic [7:0]  dir_wr_data;
  logic [7:0]  dir_rd_data;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #10 clk = ~clk;

  fregs_mem u0 (.*);

  // {bsr, banked, field, dir_addr, wdata, expected}
  localparam int NV = 9;
  localparam logic [40:0] VEC [NV] = '{
    {4'h0, 1'b0, 8'h10, 12'h010, 8'h11, 8'h11},   // R2
    {4'h2, 1'b0, 8'h7F, 12'h07F, 8'h22, 8'h22},   // R2 bank ignored
    {4'h1, 1'b0, 8'h80, 12'hF80, 8'h33, 8'h33},   // R3
    {4'h0, 1'b0, 8'hFF, 12'hFFF, 8'h44, 8'h44},   // R3
    {4'h1, 1'b1, 8'h70, 12'h170, 8'h55, 8'h55},   // R1
    {4'h2, 1'b1, 8'hA0, 12'h2A0, 8'h66, 8'h66},   // R1
    {4'hF, 1'b1, 8'h90, 12'hF90, 8'h77, 8'h77},   // R1
    {4'h5, 1'b1, 8'h20, 12'h520, 8'h88, 8'h00},   // R6
    {4'hF, 1'b1, 8'h10, 12'hF10, 8'h99, 8'h00}    // R6
  };

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #5;
  endtask

  task automatic idle();
    bsr_load = 0; wr_en = 0; dir_wr_en = 0;
  endtask

  task automatic dwrite(input logic [11:0] a, input logic [7:0] d);
    dir_addr = a; dir_wr_data = d; dir_wr_en = 1;
    step();
    dir_wr_en = 0;
  endtask

  task automatic setbsr(input logic [3:0] b);
    bsr_lit = b; bsr_load = 1;
    step();
    bsr_load = 0;
  endtask

  initial begin
    rst_n = 0; idle();
    bsr_lit = 0; rd_field = 0; rd_banked = 0; wr_field = 0; wr_banked = 0;
    wr_data = 0; dir_addr = 0; dir_wr_data = 0;
    repeat (3) step();
    rst_n = 1;
    repeat (3) step();

    // R4 reset value: banked read uses bank 0
    dwrite(12'h034, 8'h5C);
    rd_banked = 1; rd_field = 8'h34; #1;
    check("R4 reset bank", rd_data, 8'h5C);

    // vector table
    for (int i = 0; i < NV; i++) begin
      setbsr(VEC[i][40:37]);
      dwrite(VEC[i][27:16], VEC[i][15:8]);
      rd_banked = VEC[i][36]; rd_field = VEC[i][35:28];
      #1;
      check($sformatf("R1/R2/R3/R6 vec%0d field read", i), rd_data, VEC[i][7:0]);
      check($sformatf("R5 vec%0d direct read", i), dir_rd_data, VEC[i][7:0]);
    end

    // R5: direct port ignores bank register
    setbsr(4'h7);
    dir_addr = 12'h010; #1;
    check("R5 direct ignores bank", dir_rd_data, 8'h11);

    // R4: load and banked write in the same edge
    dwrite(12'h240, 8'h00);
    setbsr(4'h1);
    bsr_lit = 4'h2; bsr_load = 1;
    wr_en = 1; wr_banked = 1; wr_field = 8'h40; wr_data = 8'hC3;
    step(); idle();
    dir_addr = 12'h140; #1;
    check("R4 write uses old bank", dir_rd_data, 8'hC3);
    dir_addr = 12'h240; #1;
    check("R4 new bank untouched", dir_rd_data, 8'h00);
    rd_banked = 1; rd_field = 8'h40; #1;
    check("R4 load taken", rd_data, 8'h00);

    // R8 / R7: read during write, then after edge
    dwrite(12'h005, 8'h01);
    rd_banked = 0; rd_field = 8'h05;
    wr_banked = 0; wr_field = 8'h05; wr_data = 8'h02; wr_en = 1;
    #1;
    check("R8 old value same cycle", rd_data, 8'h01);
    step(); wr_en = 0; #1;
    check("R7 written at edge", rd_data, 8'h02);
    wr_data = 8'hEE; step(); #1;
    check("R7 no write without enable", rd_data, 8'h02);

    // R9: both ports to the same byte, then to different bytes
    wr_en = 1; wr_field = 8'h06; wr_data = 8'hA1;
    dir_wr_en = 1; dir_addr = 12'h006; dir_wr_data = 8'hB2;
    step(); idle();
    rd_field = 8'h06; #1;
    check("R9 field port wins", rd_data, 8'hA1);
    wr_en = 1; wr_field = 8'h07; wr_data = 8'h5A;
    dir_wr_en = 1; dir_addr = 12'h008; dir_wr_data = 8'hA5;
    step(); idle();
    rd_field = 8'h07; #1;
    check("R9 field write lands", rd_data, 8'h5A);
    #1;
    check("R9 direct write lands", dir_rd_data, 8'hA5);

    // R6: write to absent byte dropped, quick-high above reads zero
    dwrite(12'h300, 8'h3C);
    dir_addr = 12'h300; #1;
    check("R6 absent write dropped", dir_rd_data, 8'h00);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual hung expected done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule